// File: doc/BRIEF.md
# Escalating Multi-Stage Watchdog

This block supervises software through five escalation stages. One strobe is picked from a bank of periodic-timer expiry strobes. Each strobe that arrives while the watchdog runs, and before software restarts it, moves an expiration level up by one. When the level reaches a stage, that stage's action fires. The actions, in stage order, are a local interrupt, a fast interrupt, a remote interrupt, a debug reset and a power-on reset. Each action has its own enable bit. A per-stage skip count lets the level jump past stages whose actions are not wanted, so the full escalation still takes the intended time.

Software reaches the block through a plain single-cycle register port. A write is one cycle with `wr_en` high. A read is combinational from `rd_addr`. There are five registers: setup, status, command, key and skip. A start command restarts the watchdog, so software feeds it by writing start again. A stop command only takes effect straight after the key register has been written with the magic value. An error flag compares the level with a programmable threshold. The register port is control traffic and carries no flow control.

Top module: `wdog_escalator`

## Requirements
- R1: After reset the watchdog is stopped with level 0. The setup register (offset 0x00) reads 0x0070_0000, with a threshold of 7 and every enable clear. `act_o` and `err_o` are low.
- R2: Writing the command register (offset 0x08) with bit 0 set starts the watchdog. The same write clears the level to 0 and clears the pending-interrupt flag. Start takes priority over a strobe in the same cycle.
- R3: Only `tick_i[sel]` advances the level, where sel is setup bits [3:0]. Strobes on all other timer lines are ignored.
- R4: An expiry acted on at level L (L<5) drives `act_o[L]` high for exactly one cycle, on the clock edge that samples the strobe, provided setup bit 12+L is set. The act_o bits are 0 local interrupt, 1 fast interrupt, 2 remote interrupt, 3 debug reset and 4 power-on reset.
- R5: The skip register (offset 0x10) holds a 3-bit count for stage L in bits [4L+2:4L]. An expiry at level L moves the level to min(L+1+count, 5), and the stages passed over raise no action.
- R6: At level 5, further strobes change nothing and raise no action.
- R7: `err_o` is high exactly when the level is greater than or equal to setup bits [22:20].
- R8: A command write with bit 1 set stops the watchdog only if the write immediately before it put 0xC45A into the key register (offset 0x0C). Any other write uses up the key. A stop without a key is ignored.
- R9: While `dbg_halt_i` is high and setup bit 25 is clear, strobes are ignored. With bit 25 set, strobes count during halt.
- R10: With setup bit 4 clear (one-shot), the watchdog stops itself after the first expiry it acts on.
- R11: Once setup bit 12 is set, later writes to the setup register are ignored until reset.
- R12: The status register (offset 0x04) reads bit 0 running, bit 1 pending interrupt and bits [6:4] level. The pending flag is set by a stage-0 expiry while bit 12 is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Read byte offset |
| rd_data | output | 32 | Read data, combinational |
| tick_i | input | 16 | Expiry strobes from the periodic timers |
| dbg_halt_i | input | 1 | Debug halt, freezes counting unless overridden |
| act_o | output | 5 | One-cycle stage action pulses |
| err_o | output | 1 | Level at or above threshold |

## Verification
A write presented in one cycle is visible at the register and status reads once the next rising edge has passed. A strobe is acted on at the edge that samples it. The new level, the `err_o` change and the one-cycle `act_o` pulse all appear together after that same edge. The bench drives every input on a falling edge and reads results on the following falling edge. It gathers `act_o` during the strobe's cycle, before the pulse drops. It reads status through the combinational read port one time unit after setting the address.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int STAGES  = 5;
  localparam int SKIP_W  = 3;
  localparam int FIELD_W = 4;
  localparam int ADDR_W  = 5;
  localparam int DATA_W  = 32;

  localparam logic [ADDR_W-1:0] A_SETUP = 5'h00;
  localparam logic [ADDR_W-1:0] A_STAT  = 5'h04;
  localparam logic [ADDR_W-1:0] A_CMD   = 5'h08;
  localparam logic [ADDR_W-1:0] A_KEY   = 5'h0C;
  localparam logic [ADDR_W-1:0] A_SKIP  = 5'h10;

  localparam logic [15:0]       KEY_VAL    = 16'hC45A;
  localparam logic [DATA_W-1:0] SETUP_RST  = 32'h0070_0000;
  localparam logic [DATA_W-1:0] SETUP_MASK = 32'h0271_F01F;

  localparam int B_PERIODIC = 4;
  localparam int B_EN_LSB   = 12;
  localparam int B_THR_LSB  = 20;
  localparam int B_NOFREEZE = 25;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  logic [DATA_W-1:0]           wr_data,
  output logic [DATA_W-1:0]           setup_q,
  output logic [STAGES*FIELD_W-1:0]   skip_q,
  output logic                        start_p,
  output logic                        stop_p
);
  localparam int SKW = STAGES * FIELD_W;

  function automatic logic [SKW-1:0] skip_mask();
    logic [SKW-1:0] m;
    m = '0;
    for (int s = 0; s < STAGES; s++) m[s*FIELD_W +: SKIP_W] = '1;
    return m;
  endfunction

  localparam logic [SKW-1:0] SKMASK = skip_mask();

  logic keyed;
  logic locked;

  assign locked  = setup_q[B_EN_LSB];
  assign start_p = wr_en && (wr_addr == A_CMD) && wr_data[0];
  assign stop_p  = wr_en && (wr_addr == A_CMD) && wr_data[1] && keyed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setup_q <= SETUP_RST;
      skip_q  <= '0;
      keyed   <= 1'b0;
    end else if (wr_en) begin
      keyed <= (wr_addr == A_KEY) && (wr_data[15:0] == KEY_VAL);
      if (wr_addr == A_SETUP && !locked) setup_q <= wr_data & SETUP_MASK;
      if (wr_addr == A_SKIP) skip_q <= wr_data[SKW-1:0] & SKMASK;
    end
  end

  // R11
  setup_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(setup_q));
endmodule

// File: rtl/wdog_tick_sel.sv
module wdog_tick_sel #(
  parameter int NUM_TMR = 16,
  localparam int SEL_W  = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1
) (
  input  logic [NUM_TMR-1:0] tick_i,
  input  logic [3:0]         sel,
  input  logic               dbg_halt_i,
  input  logic               no_freeze,
  output logic               tick
);
  logic picked;
  always_comb begin
    picked = 1'b0;
    for (int t = 0; t < NUM_TMR; t++)
      if (sel == 4'(t)) picked = tick_i[t];
  end
  assign tick = picked && !(dbg_halt_i && !no_freeze);
endmodule

// File: rtl/wdog_level.sv
module wdog_level
  import wdog_pkg::*;
#(
  localparam int LVL_W = $clog2(STAGES + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       tick,
  input  logic                       start_p,
  input  logic                       stop_p,
  input  logic                       periodic,
  input  logic [STAGES-1:0]          en,
  input  logic [STAGES*FIELD_W-1:0]  skip,
  output logic [LVL_W-1:0]           level,
  output logic                       running,
  output logic                       pending,
  output logic [STAGES-1:0]          act
);
  localparam int NW = LVL_W + SKIP_W + 1;

  logic [SKIP_W-1:0] cur_skip;
  logic              cur_en;
  logic [NW-1:0]     sum;
  logic [LVL_W-1:0]  nxt;
  logic              advance;

  always_comb begin
    cur_skip = '0;
    cur_en   = 1'b0;
    for (int s = 0; s < STAGES; s++)
      if (level == LVL_W'(s)) begin
        cur_skip = skip[s*FIELD_W +: SKIP_W];
        cur_en   = en[s];
      end
    sum = NW'(level) + NW'(1) + NW'(cur_skip);
    nxt = (sum > NW'(STAGES)) ? LVL_W'(STAGES) : sum[LVL_W-1:0];
  end

  assign advance = running && tick && (level < LVL_W'(STAGES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level   <= '0;
      running <= 1'b0;
      pending <= 1'b0;
      act     <= '0;
    end else begin
      act <= '0;
      if (start_p) begin
        level   <= '0;
        running <= 1'b1;
        pending <= 1'b0;
      end else if (stop_p) begin
        running <= 1'b0;
      end else if (advance) begin
        level <= nxt;
        for (int s = 0; s < STAGES; s++)
          if (level == LVL_W'(s)) act[s] <= cur_en;
        if (level == '0 && cur_en) pending <= 1'b1;
        if (!periodic) running <= 1'b0;
      end
    end
  end

  // R4
  act_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act));
  // R2
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> (level == '0 && running && !pending));
  // R5
  lvl_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_p |=> level >= $past(level));
  // R6
  top_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level == LVL_W'(STAGES) && !start_p) |=> (level == LVL_W'(STAGES) && act == '0));
endmodule

// File: rtl/wdog_escalator.sv
module wdog_escalator
  import wdog_pkg::*;
#(
  parameter int NUM_TMR = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [ADDR_W-1:0]   rd_addr,
  output logic [DATA_W-1:0]   rd_data,
  input  logic [NUM_TMR-1:0]  tick_i,
  input  logic                dbg_halt_i,
  output logic [STAGES-1:0]   act_o,
  output logic                err_o
);
  localparam int LVL_W = $clog2(STAGES + 1);

  logic [DATA_W-1:0]         setup_q;
  logic [STAGES*FIELD_W-1:0] skip_q;
  logic                      start_p, stop_p, tick;
  logic [LVL_W-1:0]          level;
  logic                      running, pending;
  logic [2:0]                thr;

  wdog_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .setup_q(setup_q), .skip_q(skip_q),
    .start_p(start_p), .stop_p(stop_p)
  );

  wdog_tick_sel #(.NUM_TMR(NUM_TMR)) u_sel (
    .tick_i(tick_i), .sel(setup_q[3:0]), .dbg_halt_i(dbg_halt_i),
    .no_freeze(setup_q[B_NOFREEZE]), .tick(tick)
  );

  wdog_level u_lvl (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start_p(start_p),
    .stop_p(stop_p), .periodic(setup_q[B_PERIODIC]),
    .en(setup_q[B_EN_LSB +: STAGES]), .skip(skip_q),
    .level(level), .running(running), .pending(pending), .act(act_o)
  );

  assign thr   = setup_q[B_THR_LSB +: 3];
  assign err_o = (3'(level) >= thr);

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_SETUP: rd_data = setup_q;
      A_STAT: begin
        rd_data[0]   = running;
        rd_data[1]   = pending;
        rd_data[6:4] = 3'(level);
      end
      A_SKIP:  rd_data[STAGES*FIELD_W-1:0] = skip_q;
      default: rd_data = '0;
    endcase
  end

  // R8
  stop_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_p && !start_p) |=> !running);
endmodule

// File: tb/wdog_escalator_tb.sv
module wdog_escalator_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [4:0]  wr_addr = 0;
  logic [31:0] wr_data = 0;
  logic [4:0]  rd_addr = 0;
  logic [31:0] rd_data;
  logic [15:0] tick_i = 0;
  logic        dbg_halt_i = 0;
  logic [4:0]  act_o;
  logic        err_o;

  int checks = 0;
  int failures = 0;
  logic [4:0] act_acc;
  bit done = 0;

  wdog_escalator u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .tick_i(tick_i), .dbg_halt_i(dbg_halt_i), .act_o(act_o), .err_o(err_o)
  );

  always #4 clk = ~clk;

  typedef struct packed {
    logic [31:0] skip;
    logic [3:0]  nticks;
    logic [2:0]  lvl;
    logic [4:0]  mask;
  } vec_t;

  // setup enables stages 1..4 only: stage 0 action stays quiet
  localparam vec_t VECS [7] = '{
    '{32'h0000_0000, 4'd2, 3'd2, 5'b00010},
    '{32'h0000_0000, 4'd5, 3'd5, 5'b11110},
    '{32'h0000_0002, 4'd2, 3'd4, 5'b01000},
    '{32'h0000_0200, 4'd3, 3'd5, 5'b00110},
    '{32'h0000_1000, 4'd4, 3'd5, 5'b01110},
    '{32'h0000_0007, 4'd1, 3'd5, 5'b00000},
    '{32'h0000_0000, 4'd7, 3'd5, 5'b11110}
  };

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic tick(int idx);
    @(negedge clk);
    tick_i[idx] = 1'b1;
    @(negedge clk);
    act_acc = act_acc | act_o;
    tick_i = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    rd(5'h04, d); chk("R1 status", d, 32'h0);
    rd(5'h00, d); chk("R1 setup", d, 32'h0070_0000);
    chk("R1 err", {31'b0, err_o}, 32'h0);
    chk("R1 act", {27'b0, act_o}, 32'h0);

    // R3 only selected timer counts
    wr(5'h00, 32'h0071_E013);
    wr(5'h08, 32'h1);
    act_acc = 0;
    tick(2);
    rd(5'h04, d); chk("R3 other line", d, 32'h01);
    tick(3);
    rd(5'h04, d); chk("R3 selected line", d, 32'h11);

    // R9 freeze
    dbg_halt_i = 1;
    tick(3);
    rd(5'h04, d); chk("R9 frozen", d, 32'h11);
    wr(5'h00, 32'h0271_E013);
    act_acc = 0;
    tick(3);
    rd(5'h04, d); chk("R9 no-freeze counts", d, 32'h21);
    chk("R9 R4 act fast", {27'b0, act_acc}, 32'h2);
    dbg_halt_i = 0;
    wr(5'h00, 32'h0071_E013);

    // R4 R5 R6 table
    foreach (VECS[i]) begin
      wr(5'h10, VECS[i].skip);
      wr(5'h08, 32'h1);
      act_acc = 0;
      for (int k = 0; k < int'(VECS[i].nticks); k++) tick(3);
      rd(5'h04, d);
      chk("R5 R6 level", {25'b0, d[6:4], 4'b0}, {25'b0, VECS[i].lvl, 4'b0});
      chk("R4 R5 actions", {27'b0, act_acc}, {27'b0, VECS[i].mask});
    end

    // R7 error threshold 2
    wr(5'h10, 32'h0);
    wr(5'h00, 32'h0021_E013);
    wr(5'h08, 32'h1);
    chk("R7 level0", {31'b0, err_o}, 32'h0);
    tick(3);
    chk("R7 level1", {31'b0, err_o}, 32'h0);
    tick(3);
    chk("R7 level2", {31'b0, err_o}, 32'h1);

    // R8 stop protection
    wr(5'h08, 32'h2);
    rd(5'h04, d); chk("R8 stop without key", d, 32'h21);
    wr(5'h0C, 32'h0000_C45A);
    wr(5'h10, 32'h0);
    wr(5'h08, 32'h2);
    rd(5'h04, d); chk("R8 key used up", d, 32'h21);
    wr(5'h0C, 32'h0000_C45A);
    wr(5'h08, 32'h2);
    rd(5'h04, d); chk("R8 keyed stop", d, 32'h20);
    tick(3);
    rd(5'h04, d); chk("R8 stopped ignores tick", d, 32'h20);

    // R10 one-shot
    wr(5'h00, 32'h0071_E003);
    wr(5'h08, 32'h1);
    tick(3);
    rd(5'h04, d); chk("R10 one-shot stop", d, 32'h10);
    tick(3);
    rd(5'h04, d); chk("R10 no further count", d, 32'h10);

    // R11 R12 R4 local stage and lock
    wr(5'h00, 32'h0071_F013);
    wr(5'h08, 32'h1);
    act_acc = 0;
    tick(3);
    chk("R4 local act", {27'b0, act_acc}, 32'h1);
    rd(5'h04, d); chk("R12 pending", d, 32'h13);
    wr(5'h00, 32'h0);
    rd(5'h00, d); chk("R11 setup locked", d, 32'h0071_F013);
    wr(5'h08, 32'h1);
    rd(5'h04, d); chk("R2 restart clears", d, 32'h01);

    finish_run();
  end
endmodule